// File: doc/BRIEF.md
# Two-Tier Masked Interrupt Aggregator

This block collects interrupt events for a network controller and folds them into a single interrupt line through two tiers. The lower tier captures eight single-cycle event pulses into a sticky event register, qualified by an eight-bit enable mask. The upper tier holds a cause byte. Its most significant bit summarises whether any enabled lower-tier event is pending. Four further bits capture separate top-level cause pulses. A second mask gates the upper tier onto the interrupt output.

Software reaches the four registers through a byte-wide port. Event and cause bits are acknowledged by writing ones to them. The upper mask is normally written with one of two fixed codes: 0x00 silences every cause, and 0xF8 lets all five implemented causes through. Register reads are combinational from the registers. Writes take effect at the next clock edge.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset all four registers read 0x00 and irq_o is low. Address map: 0 = event register, 1 = event mask, 2 = cause register, 3 = cause mask.
- R2: A pulse on inner_evt_i[k] sets bit k of the event register, readable at address 0 after the next clock edge. Bit meanings from bit 0 upward are: fragment counter, receive done, transmit done, receive error, transmit error, FIFO error, bus error, receive buffer full.
- R3: Writing to address 0 clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a set pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set. This applies to both the event register and the cause register.
- R5: Address 1 is a plain 8-bit read/write event mask. Cause bit 7 reads 1 exactly when some event bit and its mask bit are both 1.
- R6: Cause bit 7 follows the event and mask registers with no extra write. Clearing the last enabled pending event drops it, and writing 1 to cause bit 7 has no effect on it.
- R7: A pulse on top_evt_i[i] sets cause bit 3+i. Bit 4 (top_evt_i[1]) is the authentication-challenge-ready cause. These bits clear by writing 1 at address 2. Cause bits 2..0 always read 0.
- R8: Address 3 stores only bits 7..3 and bits 2..0 read 0. Writing 0x00 masks every cause, and writing 0xF8 enables all of them.
- R9: irq_o is high exactly when some cause bit and its cause-mask bit are both 1. It responds in the same cycle as the register change, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inner_evt_i | input | 8 | Single-cycle lower-tier event pulses |
| top_evt_i | input | 4 | Single-cycle top-level cause pulses (cause bits 6..3) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives a pulse and an acknowledge onto the same bit in the same cycle. A design that lets the clear win would lose that event and read 0 where 1 is expected. It clears the only enabled pending event and then checks that cause bit 7 and irq_o fall with no further write. A design that stored the summary as a sticky bit would keep the interrupt asserted. It writes a one to cause bit 7 while an enabled event is pending, and writes an event bit with 0. A design that treated either write as a plain store would lose state. Finally, it loads the cause mask with 0x00, 0xF8 and a value with only low bits set. This catches a mask that leaks the interrupt, or one that stores the unimplemented low bits.

// File: rtl/irq_pkg.sv
// Package: shared register selects for the two-tier interrupt aggregator.
// Assumes a four-register map decoded from a 2-bit address.
package irq_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef enum logic [1:0] {
        SEL_EVT        = 2'd0,
        SEL_EVT_MASK   = 2'd1,
        SEL_CAUSE      = 2'd2,
        SEL_CAUSE_MASK = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_w1c_bank.sv
// Module: sticky bank of event bits. A set pulse latches a bit. A write
// strobe clears every bit written as 1. A set in the same cycle as a clear
// wins. Assumes set pulses are synchronous to clk.
module irq_w1c_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] clr_vec;

    // Purpose: select which bits this cycle's write acknowledges.
    always_comb begin
        clr_vec = clr_wr_i ? clr_data_i : '0;
    end

    // Purpose: hold bits, apply the clear, then let new pulses override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_vec) | set_i;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: plain writable mask register, reset to all-masked (zero).
// Assumes the caller has already decoded the write strobe.
module irq_mask_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] q_o
);
    // Purpose: store the mask on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (wr_i) begin
            q_o <= data_i;
        end
    end
endmodule

// File: rtl/irq_cascade_top.sv
// Module: two-tier interrupt aggregator. The lower tier holds sticky event
// bits gated by an event mask. The upper tier holds a cause byte whose bit 7
// summarises the enabled lower tier and whose next bits hold top-level
// causes. The cause mask gates the upper tier onto irq_o.
// Assumes single-cycle pulses and a byte register port with combinational
// reads.
module irq_cascade_top
    import irq_pkg::*;
#(
    parameter int unsigned EVT_W  = 8,
    parameter int unsigned TOP_N  = 4,
    parameter int unsigned TOP_LO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W-1:0]   inner_evt_i,
    input  logic [TOP_N-1:0]   top_evt_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [BYTE_W-1:0]  reg_wdata_i,
    output logic [BYTE_W-1:0]  reg_rdata_o,
    output logic               irq_o
);
    localparam int unsigned CAUSE_HI = TOP_LO + TOP_N;   // summary bit index
    localparam int unsigned CMSK_W   = TOP_N + 1;        // stored mask bits

    logic [EVT_W-1:0]  evt_q;
    logic [EVT_W-1:0]  evt_msk_q;
    logic [TOP_N-1:0]  top_q;
    logic [CMSK_W-1:0] cause_msk_q;
    logic              evt_pend;
    logic [BYTE_W-1:0] cause_byte;
    logic [BYTE_W-1:0] cmsk_byte;
    logic              wr_evt, wr_emsk, wr_cause, wr_cmsk;

    // Purpose: decode the write strobe per register.
    always_comb begin
        wr_evt   = reg_wr_i && (reg_addr_i == SEL_EVT);
        wr_emsk  = reg_wr_i && (reg_addr_i == SEL_EVT_MASK);
        wr_cause = reg_wr_i && (reg_addr_i == SEL_CAUSE);
        wr_cmsk  = reg_wr_i && (reg_addr_i == SEL_CAUSE_MASK);
    end

    irq_w1c_bank #(.W(EVT_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (inner_evt_i),
        .clr_wr_i   (wr_evt),
        .clr_data_i (reg_wdata_i[EVT_W-1:0]),
        .q_o        (evt_q)
    );

    irq_mask_reg #(.W(EVT_W)) u_evt_msk (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_emsk),
        .data_i (reg_wdata_i[EVT_W-1:0]),
        .q_o    (evt_msk_q)
    );

    irq_w1c_bank #(.W(TOP_N)) u_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (top_evt_i),
        .clr_wr_i   (wr_cause),
        .clr_data_i (reg_wdata_i[CAUSE_HI-1:TOP_LO]),
        .q_o        (top_q)
    );

    irq_mask_reg #(.W(CMSK_W)) u_cause_msk (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_cmsk),
        .data_i (reg_wdata_i[CAUSE_HI:TOP_LO]),
        .q_o    (cause_msk_q)
    );

    // Purpose: build the cause byte with a live summary bit.
    always_comb begin
        evt_pend   = |(evt_q & evt_msk_q);
        cause_byte = '0;
        cmsk_byte  = '0;
        cause_byte[CAUSE_HI]          = evt_pend;
        cause_byte[CAUSE_HI-1:TOP_LO] = top_q;
        cmsk_byte[CAUSE_HI:TOP_LO]    = cause_msk_q;
    end

    // Purpose: drive the interrupt line from enabled causes.
    always_comb begin
        irq_o = |(cause_byte & cmsk_byte);
    end

    // Purpose: return the selected register.
    always_comb begin
        unique case (reg_addr_i)
            SEL_EVT:        reg_rdata_o = evt_q;
            SEL_EVT_MASK:   reg_rdata_o = evt_msk_q;
            SEL_CAUSE:      reg_rdata_o = cause_byte;
            default:        reg_rdata_o = cmsk_byte;
        endcase
    end
endmodule

// File: rtl/irq_cascade_chk.sv
// Module: property checker for irq_cascade_top, attached through bind.
// Assumes the default parameter values of the top module.
module irq_cascade_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] inner_evt_i,
    input logic [3:0] top_evt_i,
    input logic       reg_wr_i,
    input logic [1:0] reg_addr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       irq_o,
    input logic [7:0] evt_q,
    input logic [7:0] evt_msk_q,
    input logic [3:0] top_q,
    input logic [4:0] cause_msk_q
);
    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_evt_i != 8'h00) |=> ((evt_q & $past(inner_evt_i)) == $past(inner_evt_i))); // R4
    AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd0) |=> ((evt_q & $past(reg_wdata_i & ~inner_evt_i)) == 8'h00)); // R3
    AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr_i && reg_addr_i == 2'd0) && inner_evt_i == 8'h00) |=> $stable(evt_q)); // R3
    AST_TOP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (top_evt_i != 4'h0) |=> ((top_q & $past(top_evt_i)) == $past(top_evt_i))); // R4
    AST_SUMMARY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 2'd2 && (evt_q & evt_msk_q) == 8'h00) |-> !reg_rdata_o[7]); // R6
    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_msk_q == 5'h00) |-> !irq_o); // R8
    AST_NO_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & evt_msk_q) == 8'h00 && top_q == 4'h0) |-> !irq_o); // R9
endmodule

bind irq_cascade_top irq_cascade_chk u_chk (.*);

// File: tb/irq_cascade_top_test.sv
module irq_cascade_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] inner_evt_i = '0;
    logic [3:0] top_evt_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_cascade_top uut (
        .clk(clk), .rst_n(rst_n), .inner_evt_i(inner_evt_i), .top_evt_i(top_evt_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // All drives happen at negedge; a write lands at the following posedge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [7:0] ie, input logic [3:0] te);
        @(negedge clk);
        inner_evt_i = ie; top_evt_i = te;
        @(negedge clk);
        inner_evt_i = '0; top_evt_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 reset register", d, 8'h00);
        end
        chk("R1 reset irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_inner_layout();
        logic [7:0] d;
        pulse(8'h02, 4'h0);                 // receive done
        rd(2'd0, d); chk("R2 receive-done bit1", d, 8'h02);
        pulse(8'h80, 4'h0);                 // receive buffer full
        rd(2'd0, d); chk("R2 rx-full bit7", d, 8'h82);
        rd(2'd2, d); chk("R5 unmasked no summary", d, 8'h00);
        chk("R9 irq low while masked", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_masking();
        logic [7:0] d;
        wr(2'd1, 8'h02);
        rd(2'd1, d); chk("R5 mask readback", d, 8'h02);
        rd(2'd2, d); chk("R5 summary set", d, 8'h80);
        chk("R8 outer mask zero blocks", {7'b0, irq_o}, 8'h00);
        wr(2'd3, 8'hF8);
        rd(2'd3, d); chk("R8 enable code readback", d, 8'hF8);
        chk("R9 irq asserted", {7'b0, irq_o}, 8'h01);
        wr(2'd2, 8'h80);                    // write 1 to summary bit
        rd(2'd2, d); chk("R6 summary ignores write", d, 8'h80);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R3 zero write keeps", d, 8'h82);
        wr(2'd0, 8'h02);
        rd(2'd0, d); chk("R3 one clears bit1", d, 8'h80);
        rd(2'd2, d); chk("R6 summary drops", d, 8'h00);
        chk("R9 irq drops", {7'b0, irq_o}, 8'h00);
        wr(2'd0, 8'h80);
        rd(2'd0, d); chk("R3 clear bit7", d, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        pulse(8'h04, 4'h0);
        @(negedge clk);
        inner_evt_i = 8'h04; top_evt_i = 4'h2;
        reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h04;
        @(negedge clk);
        inner_evt_i = '0; top_evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        rd(2'd0, d); chk("R4 event set beats clear", d, 8'h04);
        @(negedge clk);
        top_evt_i = 4'h2;
        reg_wr_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 8'h10;
        @(negedge clk);
        top_evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        rd(2'd2, d); chk("R4 cause set beats clear", d, 8'h10);
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h10);
        rd(2'd2, d); chk("R7 cause cleared", d, 8'h00);
    endtask

    task automatic t_top_causes();
        logic [7:0] d;
        pulse(8'h00, 4'h2);                 // challenge ready -> bit4
        rd(2'd2, d); chk("R7 challenge on bit4", d, 8'h10);
        chk("R9 irq from challenge", {7'b0, irq_o}, 8'h01);
        pulse(8'h00, 4'h9);                 // bits 6 and 3
        rd(2'd2, d); chk("R7 bits 6 and 3", d, 8'h58);
        wr(2'd3, 8'h00);
        chk("R8 mask-all silences", {7'b0, irq_o}, 8'h00);
        wr(2'd3, 8'h07);
        rd(2'd3, d); chk("R8 low mask bits unstored", d, 8'h00);
        wr(2'd3, 8'hF8);
        wr(2'd2, 8'h17);                    // clear bit4, low bits ignored
        rd(2'd2, d); chk("R7 w1c bit4 only", d, 8'h48);
        wr(2'd2, 8'h48);
        rd(2'd2, d); chk("R7 all cleared", d, 8'h00);
        chk("R9 irq low at end", {7'b0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inner_layout();
        t_masking();
        t_w1c();
        t_collision();
        t_top_causes();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule